// File: doc/BRIEF.md
# Pseudo Network Adapter Command Mailbox

This block is the host-facing register front end of a simple pseudo network adapter. The host reaches it through four word-addressed registers: command, status, length and a byte-wide data port. The data port reads and writes an internal packet buffer through a cursor that advances by one byte per access. To issue a command, the host first loads the length, then pushes exactly that many bytes through the data port, and then writes the opcode. When the command finishes, the block writes back a status code and an output length and moves the cursor back to zero. The host can then read the results straight out of the data port.

Transmit hands the loaded bytes to the line side on a valid/ready byte stream. Receive takes one frame from a neighbouring receive ring, which supplies its queue depth and a valid/ready byte stream. The receive ring itself is outside this block. A set of small commands reports a version constant, the station address and the ring depth, flushes the ring, and controls one level interrupt. Protocol misuse by the host sets a sticky error flag, and the offending access is otherwise discarded.

The transmit stream obeys the usual back-pressure rule. Once tx_valid is high, tx_data and tx_last hold until the line side raises tx_ready, and a beat moves only on an edge where both are high. The receive stream follows the same rule with the roles swapped. rx_ready is high throughout a receive command, and each edge with rx_valid high moves one byte.

Top module: `pnic_mailbox`

## Requirements
- R1: After reset, status reads 0, length reads 0, busy is 0, irq is 0 and no stream is active. The command register holds the no-op code and interrupts are disabled.
- R2: Register map, using host_addr: 0 is command (write only, reads 0), 1 is status (read only, writes ignored), 2 is length (read and write), 3 is the data port (low 8 bits of host_wdata/host_rdata). A valid length write (value not above BUF_BYTES) sets the length and returns the cursor to 0.
- R3: Each data-port access while idle transfers the buffer byte at the cursor and then advances the cursor by one. An access made when the cursor is at or past the length is a protocol error, changes nothing, and reads 0.
- R4: A length write larger than BUF_BYTES is a protocol error and leaves the length and cursor unchanged.
- R5: A command written while the cursor differs from the length is a protocol error and is not executed. Status, length and cursor stay as they were.
- R6: Opcodes: 0 no-op, 1 version, 2 station address, 3 ring flush, 4 transmit, 5 receive, 6 ring depth, 7 interrupt mask, 8 force interrupt. On completion, status becomes 0 (OK), or 1 for any other opcode. Length becomes the output length, which is 0 unless stated otherwise, and the cursor becomes 0.
- R7: Version returns 2 bytes, API_VERSION least significant byte first. Station address returns 6 bytes, MAC_ADDR[47:40] first. Ring depth returns rx_count as 2 bytes, least significant first.
- R8: Ring flush drives rx_flush high for exactly one cycle. An unknown opcode gives status 1 and length 0.
- R9: Transmit sends buffer bytes 0 through length-1 in order on the tx stream, with tx_last on the final byte. tx_valid holds with stable data until tx_ready. A zero length sends nothing and completes at once.
- R10: Receive completes at once with length 0 when rx_count is 0. Otherwise it raises rx_ready, stores each byte from buffer index 0 upward, and stops after the beat carrying rx_last. The length ends as the beat count capped at BUF_BYTES, and excess bytes are dropped.
- R11: While a multi-cycle command runs (version, address, depth, transmit, receive), busy is 1. Host writes and data-port reads are then ignored.
- R12: irq equals the force flag OR (enable AND rx_count nonzero). Mask sets enable to (buffer byte 0 nonzero) and clears force. Force sets force. Completing a receive clears force.
- R13: Any protocol error makes status read 0xFFFF until reset. The error is otherwise invisible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one access per cycle high |
| host_wr | input | 1 | 1 write, 0 read |
| host_addr | input | 2 | Register select |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| busy | output | 1 | Multi-cycle command in progress |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Line side accepts byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of frame |
| rx_count | input | RXQ_W | Frames waiting in the receive ring |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block accepts receive bytes |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of frame |
| rx_flush | output | 1 | One-cycle request to empty the ring |
| irq | output | 1 | Level interrupt |

## Verification
Two events can fall on the same edge here: the closing beat of a receive, which drops busy, and a host access that arrives during that same cycle. The bench holds a length write asserted across a whole receive, with gaps in the stream, and releases it only after busy is seen low. The write must be ignored, so the length left afterwards is the frame's byte count. The second case is rx_count changing in the same window as a mask command. A behavioural model compared on every clock judges the resulting irq level.

// File: rtl/pnic_mailbox_pkg.sv
package pnic_mailbox_pkg;
  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_STAT = 2'd1,
    REG_LEN  = 2'd2,
    REG_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FILL,
    PH_TX,
    PH_RX
  } phase_e;

  localparam logic [15:0] OP_NOP    = 16'd0;
  localparam logic [15:0] OP_APIVER = 16'd1;
  localparam logic [15:0] OP_MAC    = 16'd2;
  localparam logic [15:0] OP_FLUSH  = 16'd3;
  localparam logic [15:0] OP_XMIT   = 16'd4;
  localparam logic [15:0] OP_RECV   = 16'd5;
  localparam logic [15:0] OP_QLEN   = 16'd6;
  localparam logic [15:0] OP_MASK   = 16'd7;
  localparam logic [15:0] OP_FORCE  = 16'd8;

  localparam logic [15:0] ST_OK      = 16'd0;
  localparam logic [15:0] ST_UNKNOWN = 16'd1;
  localparam logic [15:0] ST_PROTO   = 16'hFFFF;
endpackage

// File: rtl/pnic_pktbuf.sv
module pnic_pktbuf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b,
  output logic [7:0]    first_byte
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata_a    = mem_q[raddr_a];
  assign rdata_b    = mem_q[raddr_b];
  assign first_byte = mem_q[0];
endmodule

// File: rtl/pnic_irq_ctl.sv
module pnic_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_wr,
  input  logic mask_en,
  input  logic force_set,
  input  logic force_clr,
  input  logic q_nonempty,
  output logic irq
);
  logic en_q, force_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      force_q <= 1'b0;
    end else begin
      if (mask_wr) begin
        en_q    <= mask_en;
        force_q <= 1'b0;
      end else if (force_set) begin
        force_q <= 1'b1;
      end else if (force_clr) begin
        force_q <= 1'b0;
      end
    end
  end

  assign irq = force_q | (en_q & q_nonempty);

  AST_FORCE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    force_set |=> irq); // R12
  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_en) |=> !force_q && !en_q); // R12
endmodule

// File: rtl/pnic_mailbox.sv
module pnic_mailbox
  import pnic_mailbox_pkg::*;
#(
  parameter int          BUF_BYTES   = 64,
  parameter int          RXQ_W       = 8,
  parameter logic [15:0] API_VERSION = 16'h0203,
  parameter logic [47:0] MAC_ADDR    = 48'h0200_5E10_2030
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic [1:0]       host_addr,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  output logic             busy,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic [RXQ_W-1:0] rx_count,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             rx_flush,
  output logic             irq
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int CW = $clog2(BUF_BYTES + 1);
  localparam logic [CW-1:0] LEN_MAX = CW'(BUF_BYTES);

  function automatic logic [47:0] mac_le(input logic [47:0] m);
    logic [47:0] r;
    for (int k = 0; k < 6; k++) r[8*k +: 8] = m[8*(5-k) +: 8];
    return r;
  endfunction
  localparam logic [47:0] MAC_LE = mac_le(MAC_ADDR);

  phase_e        phase_q;
  logic [15:0]   status_q;
  logic          err_q;
  logic [CW-1:0] len_q, cur_q, tx_i, tx_n;
  logic [47:0]   res_q;
  logic [2:0]    fill_i, fill_n;
  logic          flush_q;

  logic          acc, len_wr, len_bad, dat_acc, dat_bad, cmd_wr, cmd_bad, cmd_go;
  logic          proto_err;
  logic          buf_we;
  logic [AW-1:0] buf_waddr;
  logic [7:0]    buf_wdata, buf_rd_host, buf_rd_tx, buf_first;
  logic [15:0]   qlen16;
  logic          mask_wr, force_set, force_clr;

  assign acc       = host_sel && (phase_q == PH_IDLE);
  assign len_wr    = acc && host_wr && (host_addr == REG_LEN);
  assign len_bad   = host_wdata > 16'(BUF_BYTES);
  assign dat_acc   = acc && (host_addr == REG_DATA);
  assign dat_bad   = cur_q >= len_q;
  assign cmd_wr    = acc && host_wr && (host_addr == REG_CMD);
  assign cmd_bad   = cur_q != len_q;
  assign cmd_go    = cmd_wr && !cmd_bad;
  assign proto_err = (len_wr && len_bad) || (dat_acc && dat_bad) || (cmd_wr && cmd_bad);
  assign qlen16    = 16'(rx_count);

  always_comb begin
    buf_we    = 1'b0;
    buf_waddr = cur_q[AW-1:0];
    buf_wdata = host_wdata[7:0];
    unique case (phase_q)
      PH_FILL: begin
        buf_we    = 1'b1;
        buf_waddr = AW'(fill_i);
        buf_wdata = res_q[{fill_i, 3'b000} +: 8];
      end
      PH_RX: begin
        buf_we    = rx_valid && (len_q < LEN_MAX);
        buf_waddr = len_q[AW-1:0];
        buf_wdata = rx_data;
      end
      default: buf_we = dat_acc && host_wr && !dat_bad;
    endcase
  end

  pnic_pktbuf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr_a(cur_q[AW-1:0]), .rdata_a(buf_rd_host),
    .raddr_b(tx_i[AW-1:0]), .rdata_b(buf_rd_tx), .first_byte(buf_first)
  );

  assign mask_wr   = cmd_go && (host_wdata == OP_MASK);
  assign force_set = cmd_go && (host_wdata == OP_FORCE);
  assign force_clr = (cmd_go && (host_wdata == OP_RECV) && (rx_count == '0)) ||
                     ((phase_q == PH_RX) && rx_valid && rx_last);

  pnic_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_en(|buf_first),
    .force_set(force_set), .force_clr(force_clr), .q_nonempty(rx_count != '0), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      status_q <= ST_OK;
      err_q    <= 1'b0;
      len_q    <= '0;
      cur_q    <= '0;
      tx_i     <= '0;
      tx_n     <= '0;
      res_q    <= '0;
      fill_i   <= '0;
      fill_n   <= '0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= 1'b0;
      if (proto_err) err_q <= 1'b1;
      unique case (phase_q)
        PH_FILL: begin
          if (fill_i == fill_n - 3'd1) phase_q <= PH_IDLE;
          else fill_i <= fill_i + 3'd1;
        end
        PH_TX: if (tx_ready) begin
          if (tx_i == tx_n - 1'b1) phase_q <= PH_IDLE;
          else tx_i <= tx_i + 1'b1;
        end
        PH_RX: if (rx_valid) begin
          if (len_q < LEN_MAX) len_q <= len_q + 1'b1;
          if (rx_last) phase_q <= PH_IDLE;
        end
        default: begin
          if (len_wr && !len_bad) begin
            len_q <= host_wdata[CW-1:0];
            cur_q <= '0;
          end
          if (dat_acc && !dat_bad) cur_q <= cur_q + 1'b1;
          if (cmd_go) begin
            cur_q    <= '0;
            len_q    <= '0;
            status_q <= ST_OK;
            fill_i   <= '0;
            unique case (host_wdata)
              OP_APIVER: begin
                res_q <= {32'd0, API_VERSION}; fill_n <= 3'd2;
                len_q <= CW'(2); phase_q <= PH_FILL;
              end
              OP_MAC: begin
                res_q <= MAC_LE; fill_n <= 3'd6;
                len_q <= CW'(6); phase_q <= PH_FILL;
              end
              OP_QLEN: begin
                res_q <= {32'd0, qlen16}; fill_n <= 3'd2;
                len_q <= CW'(2); phase_q <= PH_FILL;
              end
              OP_FLUSH: flush_q <= 1'b1;
              OP_XMIT: if (len_q != '0) begin
                tx_i <= '0; tx_n <= len_q; phase_q <= PH_TX;
              end
              OP_RECV: if (rx_count != '0) phase_q <= PH_RX;
              OP_NOP, OP_MASK, OP_FORCE: ;
              default: status_q <= ST_UNKNOWN;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    unique case (host_addr)
      REG_STAT: host_rdata = err_q ? ST_PROTO : status_q;
      REG_LEN:  host_rdata = 16'(len_q);
      REG_DATA: host_rdata = dat_bad ? 16'd0 : {8'd0, buf_rd_host};
      default:  host_rdata = 16'd0;
    endcase
  end

  assign busy     = phase_q != PH_IDLE;
  assign tx_valid = phase_q == PH_TX;
  assign tx_data  = buf_rd_tx;
  assign tx_last  = tx_valid && (tx_i == tx_n - 1'b1);
  assign rx_ready = phase_q == PH_RX;
  assign rx_flush = flush_q;

  AST_LEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr && host_addr == REG_LEN && !busy && host_wdata <= 16'(BUF_BYTES))
    |=> (cur_q == '0 && 16'(len_q) == $past(host_wdata))); // R2
  AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr && host_addr == REG_LEN && !busy && host_wdata > 16'(BUF_BYTES))
    |=> $stable(len_q)); // R4
  AST_CMD_CURSOR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> (cur_q == '0)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R13
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !rx_flush); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R9
  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, rx_ready})); // R11
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_MAX); // R10
endmodule

// File: tb/pnic_mailbox_tb.sv
module pnic_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        busy, tx_valid, tx_data_last, rx_ready, rx_flush, irq;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic [7:0]  rx_count = 8'd0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = 8'd0;

  always #10 clk = ~clk;

  pnic_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_data_last), .rx_count(rx_count), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_flush(rx_flush), .irq(irq)
  );

  int nvec = 0, nfail = 0;

  task automatic chk(input int act, input int exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st, m_status, m_err, m_len, m_cur, m_fi, m_fn, m_txi, m_txn, m_flush, m_en, m_force;
  int m_buf[64];
  int m_res[6];

  function automatic void m_fill(input int n, input int b0, input int b1, input int b2,
                                 input int b3, input int b4, input int b5);
    m_res = '{b0, b1, b2, b3, b4, b5};
    m_fn = n; m_fi = 0; m_len = n; m_st = 1;
  endfunction

  function automatic void m_cmd(input int op);
    int old_len;
    old_len = m_len;
    m_cur = 0; m_len = 0; m_status = 0;
    case (op)
      0: ;
      1: m_fill(2, 8'h03, 8'h02, 0, 0, 0, 0);
      2: m_fill(6, 8'h02, 8'h00, 8'h5E, 8'h10, 8'h20, 8'h30);
      3: m_flush = 1;
      4: if (old_len > 0) begin m_st = 2; m_txi = 0; m_txn = old_len; end
      5: if (rx_count != 0) m_st = 3; else m_force = 0;
      6: m_fill(2, int'(rx_count), 0, 0, 0, 0, 0);
      7: begin m_en = (m_buf[0] != 0); m_force = 0; end
      8: m_force = 1;
      default: m_status = 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_status = 0; m_err = 0; m_len = 0; m_cur = 0; m_fi = 0; m_fn = 0;
      m_txi = 0; m_txn = 0; m_flush = 0; m_en = 0; m_force = 0;
      foreach (m_buf[i]) m_buf[i] = 0;
    end else begin
      m_flush = 0;
      case (m_st)
        1: begin
          m_buf[m_fi] = m_res[m_fi];
          if (m_fi == m_fn - 1) m_st = 0; else m_fi++;
        end
        2: if (tx_ready) begin
          if (m_txi == m_txn - 1) m_st = 0; else m_txi++;
        end
        3: if (rx_valid) begin
          if (m_len < 64) begin m_buf[m_len] = int'(rx_data); m_len++; end
          if (rx_last) begin m_st = 0; m_force = 0; end
        end
        default: if (host_sel) begin
          case (host_addr)
            2'd2: if (host_wr) begin
              if (host_wdata > 64) m_err = 1;
              else begin m_len = int'(host_wdata); m_cur = 0; end
            end
            2'd3: if (m_cur >= m_len) m_err = 1;
                  else begin
                    if (host_wr) m_buf[m_cur] = int'(host_wdata[7:0]);
                    m_cur++;
                  end
            2'd0: if (host_wr) begin
              if (m_cur != m_len) m_err = 1; else m_cmd(int'(host_wdata));
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  // per-clock comparison, sampled at the falling edge
  int flush_cnt = 0;
  bit rx_fire = 0;
  int tx_seen[$];
  always @(negedge clk) begin
    int exp_rd;
    rx_fire = rx_valid && rx_ready;
    if (rx_flush) flush_cnt++;
    if (tx_valid && tx_ready) tx_seen.push_back({23'd0, tx_data_last, tx_data});
    if (rst_n) begin
      chk(busy, m_st != 0, "R11 busy");
      chk(irq, m_force || (m_en && rx_count != 0), "R12 irq");
      chk(tx_valid, m_st == 2, "R9 tx_valid");
      if (m_st == 2) begin
        chk(tx_data, m_buf[m_txi], "R9 tx_data");
        chk(tx_data_last, m_txi == m_txn - 1, "R9 tx_last");
      end
      chk(rx_ready, m_st == 3, "R10 rx_ready");
      chk(rx_flush, m_flush, "R8 rx_flush");
      if (m_st == 0) begin
        case (host_addr)
          2'd1: exp_rd = m_err ? 16'hFFFF : m_status;
          2'd2: exp_rd = m_len;
          2'd3: exp_rd = (m_cur < m_len) ? m_buf[m_cur] : 0;
          default: exp_rd = 0;
        endcase
        chk(host_rdata, exp_rd, "R2 host_rdata");
      end
    end
  end

  // line-side sources
  int rxq[$];
  int cyc = 0;
  always @(posedge clk) begin
    #2;
    if (rx_fire && rxq.size() > 0) void'(rxq.pop_front());
    cyc++;
    if (!(rx_valid && !rx_fire)) begin
      if (rxq.size() > 0 && (cyc % 4 != 2)) begin
        rx_valid = 1'b1; rx_data = rxq[0][7:0]; rx_last = rxq[0][8];
      end else begin
        rx_valid = 1'b0;
      end
    end
    tx_ready = (cyc % 3 != 1);
  end

  task automatic push_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) rxq.push_back(((i == n - 1) ? 256 : 0) + ((seed + i) & 255));
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    host_sel = 1'b1; host_wr = 1'b1; host_addr = 2'(a); host_wdata = 16'(d);
    @(posedge clk); #2;
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(posedge clk); #2;
    host_sel = 1'b1; host_wr = 1'b0; host_addr = 2'(a);
    @(negedge clk);
    chk(host_rdata, exp, tag);
    @(posedge clk); #2;
    host_sel = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) begin @(posedge clk); #2; end
  endtask

  task automatic cmd(input int op);
    wr(0, op);
    wait_idle();
  endtask

  task automatic run_tests();
    int f0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(busy, 0, "R1 busy"); chk(irq, 0, "R1 irq");
    chk(tx_valid, 0, "R1 tx_valid"); chk(rx_ready, 0, "R1 rx_ready");
    rd(1, 0, "R1 status");
    rd(2, 0, "R1 length");
    // register map
    rd(0, 0, "R2 command reads 0");
    wr(1, 16'h55);
    rd(1, 0, "R2 status write ignored");
    // length load and data port
    wr(2, 3);
    rd(2, 3, "R2 length load");
    wr(3, 8'hAA); wr(3, 8'hBB); wr(3, 8'hCC);
    cmd(0);
    rd(1, 0, "R6 no-op status"); rd(2, 0, "R6 no-op length");
    wr(2, 3);
    rd(3, 8'hAA, "R3 byte0"); rd(3, 8'hBB, "R3 byte1"); rd(3, 8'hCC, "R3 byte2");
    // version / address / depth
    cmd(1);
    rd(2, 2, "R7 version length");
    rd(3, 8'h03, "R7 version lsb"); rd(3, 8'h02, "R7 version msb");
    cmd(2);
    rd(2, 6, "R7 mac length");
    rd(3, 8'h02, "R7 mac0"); rd(3, 8'h00, "R7 mac1"); rd(3, 8'h5E, "R7 mac2");
    rd(3, 8'h10, "R7 mac3"); rd(3, 8'h20, "R7 mac4"); rd(3, 8'h30, "R7 mac5");
    rx_count = 8'd5;
    cmd(6);
    rd(2, 2, "R7 depth length");
    rd(3, 5, "R7 depth lsb"); rd(3, 0, "R7 depth msb");
    // unknown and flush
    cmd(16'h0042);
    rd(1, 1, "R8 unknown status"); rd(2, 0, "R8 unknown length");
    f0 = flush_cnt;
    cmd(3);
    repeat (3) @(posedge clk);
    chk(flush_cnt - f0, 1, "R8 single flush pulse");
    rd(1, 0, "R6 flush status");
    // transmit
    wr(2, 4); wr(3, 8'h11); wr(3, 8'h22); wr(3, 8'h33); wr(3, 8'h44);
    tx_seen.delete();
    cmd(4);
    chk(tx_seen.size(), 4, "R9 beat count");
    if (tx_seen.size() == 4) begin
      chk(tx_seen[0], 8'h11, "R9 beat0"); chk(tx_seen[1], 8'h22, "R9 beat1");
      chk(tx_seen[2], 8'h33, "R9 beat2"); chk(tx_seen[3], 9'h144, "R9 beat3 last");
    end
    rd(2, 0, "R9 tx output length");
    tx_seen.delete();
    cmd(4);
    repeat (3) @(posedge clk);
    chk(tx_seen.size(), 0, "R9 zero-length transmit");
    // receive
    rx_count = 8'd0;
    cmd(5);
    rd(2, 0, "R10 empty ring");
    rx_count = 8'd2;
    push_frame(5, 8'h60);
    cmd(5);
    rd(2, 5, "R10 rx length");
    rd(3, 8'h60, "R10 rx0"); rd(3, 8'h61, "R10 rx1"); rd(3, 8'h62, "R10 rx2");
    rd(3, 8'h63, "R10 rx3"); rd(3, 8'h64, "R10 rx4");
    push_frame(70, 8'h80);
    cmd(5);
    rd(2, 64, "R10 rx length capped");
    rd(3, 8'h80, "R10 capped rx0");
    wr(2, 0);
    // host writes held across a receive, including its final beat
    push_frame(20, 8'h10);
    wr(0, 5);
    @(posedge clk); #2;
    host_sel = 1'b1; host_wr = 1'b1; host_addr = 2'd2; host_wdata = 16'd7;
    while (busy) @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
    rd(2, 20, "R11 length write ignored while busy");
    rd(3, 8'h10, "R11 buffer intact");
    wr(2, 0);
    // interrupt control
    rx_count = 8'd0;
    wr(2, 1); wr(3, 1); cmd(7);
    @(negedge clk); chk(irq, 0, "R12 enabled, ring empty");
    @(posedge clk); #2 rx_count = 8'd3;
    @(negedge clk); chk(irq, 1, "R12 enabled, ring busy");
    wr(2, 1); wr(3, 0); cmd(7);
    @(negedge clk); chk(irq, 0, "R12 masked");
    cmd(8);
    @(negedge clk); chk(irq, 1, "R12 forced");
    @(posedge clk); #2 rx_count = 8'd0;
    cmd(5);
    @(negedge clk); chk(irq, 0, "R12 force cleared by receive");
    // protocol errors
    wr(2, 2); wr(3, 8'h5A);
    wr(0, 0);
    rd(1, 16'hFFFF, "R5 incomplete data flagged");
    rd(2, 2, "R5 command not executed");
    wr(2, 65);
    rd(2, 2, "R4 oversize length rejected");
    wr(3, 8'h6B); wr(3, 8'h7C);
    wr(2, 2);
    rd(3, 8'h5A, "R3 byte kept"); rd(3, 8'h6B, "R3 overrun write dropped");
    rd(3, 0, "R3 overrun read returns 0");
    rd(1, 16'hFFFF, "R13 error sticky");
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(1, 0, "R13 cleared by reset");
    rd(2, 0, "R1 length after reset");
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule